// File: doc/BRIEF.md
# Two-Step Parallel Chien Search

This block finds the roots of a binary BCH error-locator polynomial. It tests P consecutive codeword positions in every clock cycle. A decoder loads the locator coefficients and the codeword length through a valid/ready input. The block then streams one P-bit flag word per cycle, and each set bit marks an erroneous position. The locator is Λ(x) = 1 + λ1·x + … + λT·x^T over GF(2^M), with primitive polynomial POLY and α = x. Position k is in error exactly when Λ(α^-k) = 0. This is the same as the partial sum Y_k = Σ λj·α^(-jk) being equal to the field's one element.

To save power, every partial sum is evaluated in two steps:

- **First step.** On every cycle, each lane computes only the HI_W most-significant bits of its sum. If any of these bits is nonzero, the lane cannot hold a root.
- **Second step.** One pipeline stage later, the remaining low bits are computed and registered, but only in lanes whose top bits were all zero. In the other lanes the second-step operands are forced to zero and the second-step register is not written.

Evaluation starts at position 0. The search covers positions 0..n-1 of a shortened code, and n is given per search.

Back-pressure works as follows. While out_valid is high and out_ready is low, the whole pipeline freezes: the flag word on the outputs stays unchanged and no coefficient register advances. A new search is taken only while in_ready is high, and in_ready stays low from acceptance until the done pulse.

Top module: `chien_two_step`

## Requirements
- R1: in_ready is high when no search is active. A search is accepted on a clock edge with in_valid and in_ready both high, and in_ready is low from that edge until the cycle after done.
- R2: Bit i of output beat w refers to position k = w·P + i. It is 1 exactly when Λ(α^-k) = 0, that is, when the sum of λj·α^(-jk) over j = 1..T equals the pattern 0…01. λj is taken from in_coef[(j-1)·M +: M], and field elements are in polynomial basis with bit 0 as the constant term.
- R3: A flag bit for a position k ≥ n is always 0, even when Λ has a root there.
- R4: A search of length n yields exactly ceil(n/P) beats, in order of increasing position, and no further beat.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_flags stays unchanged in the next cycle.
- R6: out_flags is all zero whenever out_valid is low.
- R7: done is high for one cycle, exactly when the last beat of a search is transferred (out_valid and out_ready high). in_ready is high in the following cycle.
- R8: During and right after reset, in_ready is 1 and out_valid, done and out_flags are 0.
- R9: The first beat of a search becomes valid on the third rising clock edge after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficients and length are offered |
| in_ready | output | 1 | Block is idle and takes a new search |
| in_coef | input | T*M | Locator coefficients λ1..λT, λj at bits (j-1)·M upward |
| in_len | input | M | Codeword length n, 1 to 2^M-1 |
| out_valid | output | 1 | A flag word is presented |
| out_ready | input | 1 | Consumer takes the flag word |
| out_flags | output | P | Error flag per lane, bit i for position w·P+i |
| done | output | 1 | One-cycle pulse with the final beat's transfer |

## Verification
Some rules hold on every cycle and are checked by assertions:
- the input handshake closes after an acceptance and reopens after done;
- flags stay frozen while the output is stalled and are quiet when nothing is valid;
- done only comes with a transfer;
- the first beat appears a fixed number of edges after acceptance.

Other behaviour can only be shown by the bench's scenarios, which compare every flag word against a brute-force evaluation of the locator at every position:
- that each flag marks a real root;
- that roots placed beyond the shortened length stay hidden;
- that the beat count matches the length for lengths not divisible by P, including one-position codes and lengths of exactly P.

// File: rtl/chs_pkg.sv
package chs_pkg;

  localparam int GF_MAXW = 16;
  typedef logic [GF_MAXW-1:0] gf_word_t;

  // multiply a field element by alpha (= x) modulo the field polynomial
  function automatic gf_word_t gf_xtime(gf_word_t a, int m, int poly);
    gf_word_t r;
    r = a << 1;
    if (a[m-1]) r = r ^ gf_word_t'(poly);
    return r & gf_word_t'((1 << m) - 1);
  endfunction

  // general shift-and-add product; with a constant operand it folds to XORs
  function automatic gf_word_t gf_mul(gf_word_t a, gf_word_t b, int m, int poly);
    gf_word_t acc;
    acc = '0;
    for (int i = GF_MAXW - 1; i >= 0; i--) begin
      if (i < m) begin
        acc = gf_xtime(acc, m, poly);
        if (b[i]) acc = acc ^ a;
      end
    end
    return acc;
  endfunction

  // alpha^e by square-and-multiply
  function automatic gf_word_t gf_alpha_pow(int e, int m, int poly);
    gf_word_t r;
    gf_word_t b;
    r = 16'd1;
    b = 16'd2;
    for (int i = 0; i < 31; i++) begin
      if (((e >> i) & 1) != 0) r = gf_mul(r, b, m, poly);
      b = gf_mul(b, b, m, poly);
    end
    return r;
  endfunction

  // alpha^(-e)
  function automatic gf_word_t gf_alpha_neg(int e, int m, int poly);
    int nf;
    int rem;
    nf  = (1 << m) - 1;
    rem = e % nf;
    return gf_alpha_pow((nf - rem) % nf, m, poly);
  endfunction

endpackage

// File: rtl/chs_ctrl.sv
module chs_ctrl #(
  parameter int P      = 8,
  parameter int LEN_W  = 8,
  parameter int BASE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              adv,
  input  logic              done,
  output logic              in_ready,
  output logic              accept,
  output logic              run,
  output logic              last,
  output logic [BASE_W-1:0] base,
  output logic [BASE_W-1:0] len_ext
);

  logic             busy;
  logic [LEN_W-1:0] len_q;

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;
  assign len_ext  = BASE_W'(len_q);
  assign last     = (base + BASE_W'(P)) >= len_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      run   <= 1'b0;
      base  <= '0;
      len_q <= '0;
    end else begin
      if (accept) begin
        busy  <= 1'b1;
        run   <= 1'b1;
        base  <= '0;
        len_q <= in_len;
      end else begin
        if (done) busy <= 1'b0;
        if (adv && run) begin
          base <= base + BASE_W'(P);
          if (last) run <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/chs_coef_bank.sv
module chs_coef_bank import chs_pkg::*; #(
  parameter int M    = 8,
  parameter int T    = 4,
  parameter int P    = 8,
  parameter int POLY = 'h11D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [T*M-1:0] coef_in,
  output logic [T*M-1:0] coef_q
);

  // register of degree d advances by alpha^(-d*P) per search cycle
  function automatic logic [T*GF_MAXW-1:0] step_consts();
    logic [T*GF_MAXW-1:0] t;
    t = '0;
    for (int j = 0; j < T; j++)
      t[j*GF_MAXW +: GF_MAXW] = gf_alpha_neg((j + 1) * P, M, POLY);
    return t;
  endfunction

  localparam logic [T*GF_MAXW-1:0] KSTEP = step_consts();

  for (genvar j = 0; j < T; j++) begin : g_reg
    logic [M-1:0] r;
    logic [M-1:0] nxt;

    always_comb
      nxt = M'(gf_mul(gf_word_t'(r), KSTEP[j*GF_MAXW +: GF_MAXW], M, POLY));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    r <= '0;
      else if (load) r <= coef_in[j*M +: M];
      else if (step) r <= nxt;
    end

    assign coef_q[j*M +: M] = r;
  end

endmodule

// File: rtl/chs_lane_part.sv
module chs_lane_part import chs_pkg::*; #(
  parameter int M    = 8,
  parameter int T    = 4,
  parameter int LANE = 0,
  parameter int POLY = 'h11D,
  parameter int LSB  = 0,
  parameter int MSB  = 7
) (
  input  logic [T*M-1:0]   coef,
  output logic [MSB-LSB:0] part
);

  localparam int W = MSB - LSB + 1;

  // lane offset constants alpha^(-d*LANE)
  function automatic logic [T*GF_MAXW-1:0] lane_consts();
    logic [T*GF_MAXW-1:0] t;
    t = '0;
    for (int j = 0; j < T; j++)
      t[j*GF_MAXW +: GF_MAXW] = gf_alpha_neg((j + 1) * LANE, M, POLY);
    return t;
  endfunction

  localparam logic [T*GF_MAXW-1:0] KLANE = lane_consts();

  // only the requested bit slice of the sum is formed
  always_comb begin
    part = '0;
    for (int j = 0; j < T; j++)
      part = part ^ W'(gf_mul(gf_word_t'(coef[j*M +: M]),
                              KLANE[j*GF_MAXW +: GF_MAXW], M, POLY) >> LSB);
  end

endmodule

// File: rtl/chien_two_step.sv
module chien_two_step #(
  parameter int M    = 8,
  parameter int T    = 4,
  parameter int P    = 8,
  parameter int HI_W = 4,
  parameter int POLY = 'h11D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [T*M-1:0] in_coef,
  input  logic [M-1:0]   in_len,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [P-1:0]   out_flags,
  output logic           done
);

  localparam int LO_W   = M - HI_W;
  localparam int BASE_W = M + 2;

  logic              adv;
  logic              accept;
  logic              run;
  logic              last;
  logic [BASE_W-1:0] base;
  logic [BASE_W-1:0] len_ext;
  logic [T*M-1:0]    coef_q;

  // stage A: first-step outcome and coefficient snapshot
  logic           va;
  logic           last_a;
  logic [P-1:0]   en_a;
  logic [T*M-1:0] snap;
  logic [P-1:0]   en_a_nxt;

  // stage B: second-step result
  logic         vb;
  logic         last_b;
  logic [P-1:0] en_b;

  assign adv  = !(vb && !out_ready);
  assign done = vb && out_ready && last_b;

  chs_ctrl #(.P(P), .LEN_W(M), .BASE_W(BASE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_len(in_len),
    .adv(adv), .done(done), .in_ready(in_ready), .accept(accept),
    .run(run), .last(last), .base(base), .len_ext(len_ext)
  );

  chs_coef_bank #(.M(M), .T(T), .P(P), .POLY(POLY)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(adv && run),
    .coef_in(in_coef), .coef_q(coef_q)
  );

  for (genvar i = 0; i < P; i++) begin : g_lane
    logic [HI_W-1:0] hi_part;
    logic [LO_W-1:0] lo_part;
    logic [LO_W-1:0] lo_b;
    logic [T*M-1:0]  iso;

    chs_lane_part #(.M(M), .T(T), .LANE(i), .POLY(POLY),
                    .LSB(LO_W), .MSB(M-1)) u_hi (
      .coef(coef_q), .part(hi_part)
    );

    assign en_a_nxt[i] = run && (hi_part == '0) &&
                         ((base + BASE_W'(i)) < len_ext);

    // operand isolation: the second step sees zeros unless enabled
    assign iso = snap & {(T*M){en_a[i]}};

    chs_lane_part #(.M(M), .T(T), .LANE(i), .POLY(POLY),
                    .LSB(0), .MSB(LO_W-1)) u_lo (
      .coef(iso), .part(lo_part)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              lo_b <= '0;
      else if (adv && en_a[i]) lo_b <= lo_part;
    end

    assign out_flags[i] = en_b[i] && (lo_b == LO_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va     <= 1'b0;
      last_a <= 1'b0;
      en_a   <= '0;
      snap   <= '0;
      vb     <= 1'b0;
      last_b <= 1'b0;
      en_b   <= '0;
    end else if (adv) begin
      va     <= run;
      last_a <= run && last;
      en_a   <= en_a_nxt;
      if (run) snap <= coef_q;
      vb     <= va;
      last_b <= last_a;
      en_b   <= en_a;
    end
  end

  assign out_valid = vb;

endmodule

// File: rtl/chs_checker.sv
module chs_checker #(
  parameter int P = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [P-1:0] out_flags,
  input logic         done
);

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flags)));

  p_quiet_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_flags == '0));

  p_done_on_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && out_ready));

  p_ready_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);

  p_first_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 3));

endmodule

bind chien_two_step chs_checker #(.P(P)) u_chs_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_flags(out_flags),
  .done(done)
);

// File: tb/test_chien_two_step.sv
module test_chien_two_step;
  localparam int M = 8, T = 4, P = 8, HI_W = 4, POLY = 'h11D;
  localparam int NF = 255;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [T*M-1:0] in_coef = '0;
  logic [M-1:0]   in_len = '0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [P-1:0]   out_flags;
  logic           done;

  always #5 clk = ~clk;

  chien_two_step #(.M(M), .T(T), .P(P), .HI_W(HI_W), .POLY(POLY)) i_chien_two_step (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_len(in_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_flags(out_flags), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int alog [0:NF-1];
  int glog [0:NF];
  int loc  [0:T];
  int epos [0:T-1];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return alog[(glog[a] + glog[b]) % NF];
  endfunction

  function automatic bit is_root(int k);
    int x, acc, xp;
    x = alog[(NF - (k % NF)) % NF];
    acc = 0; xp = 1;
    for (int j = 0; j <= T; j++) begin
      acc = acc ^ gmul(loc[j], xp);
      xp = gmul(xp, x);
    end
    return acc == 0;
  endfunction

  task automatic build_loc(input int nerr);
    for (int j = 0; j <= T; j++) loc[j] = 0;
    loc[0] = 1;
    for (int e = 0; e < nerr; e++) begin
      int xv;
      xv = alog[epos[e]];
      for (int j = T; j >= 1; j--) loc[j] = loc[j] ^ gmul(xv, loc[j-1]);
    end
  endtask

  task automatic run_search(input int n, input int nerr, input bit bp);
    int beats, got, cyc;
    bit first, held;
    logic [P-1:0] hflags, expv;
    build_loc(nerr);
    beats = (n + P - 1) / P;
    got = 0; cyc = 0; first = 1'b1; held = 1'b0; hflags = '0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 idle ready", int'(in_ready), 1);
    for (int j = 1; j <= T; j++) in_coef[(j-1)*M +: M] = loc[j][M-1:0];
    in_len = n[M-1:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R1 busy after accept", int'(in_ready), 0);
    while (got < beats) begin
      cyc++;
      out_ready = bp ? ($urandom_range(2, 0) != 0) : 1'b1;
      #1;
      if (out_valid) begin
        if (first) chk(cyc == 3, "R9 first beat latency", cyc, 3);
        first = 1'b0;
        if (held) chk(out_flags == hflags, "R5 stalled flags held", int'(out_flags), int'(hflags));
        held = 1'b0;
        if (!out_ready) begin
          held = 1'b1;
          hflags = out_flags;
        end else begin
          for (int i = 0; i < P; i++) begin
            int k;
            k = got * P + i;
            expv[i] = (k < n) && is_root(k);
          end
          chk(out_flags == expv, "R2/R3 flag word", int'(out_flags), int'(expv));
          chk(done == (got == beats - 1), "R4/R7 done on last beat", int'(done), int'(got == beats - 1));
          got++;
        end
      end else begin
        chk(out_flags == '0, "R6 flags quiet", int'(out_flags), 0);
        if (cyc > 40 + 2 * beats * 4) begin
          chk(1'b0, "R4 beat missing", got, beats);
          got = beats;
        end
      end
      @(negedge clk);
    end
    #1;
    chk(in_ready == 1'b1, "R7 ready after done", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R4 no extra beat", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    alog[0] = 1;
    for (int i = 1; i < NF; i++) begin
      int v;
      v = alog[i-1] << 1;
      if (v & 256) v = v ^ POLY;
      alog[i] = v;
    end
    for (int i = 0; i < NF; i++) glog[alog[i]] = i;
    glog[0] = 0;

    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R8 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R8 reset out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R8 reset done", int'(done), 0);
    chk(out_flags == '0, "R8 reset flags", int'(out_flags), 0);
    rst_n = 1'b1;

    epos[0] = 0; epos[1] = 254; epos[2] = 100; epos[3] = 37;
    run_search(255, 4, 1'b0);
    run_search(255, 0, 1'b1);
    epos[0] = 12; epos[1] = 14; epos[2] = 3;
    run_search(13, 3, 1'b0);
    epos[0] = 0;
    run_search(1, 1, 1'b1);
    epos[0] = 7; epos[1] = 9;
    run_search(8, 2, 1'b0);

    for (int s = 0; s < 30; s++) begin
      int n, ne;
      n = 1 + $urandom_range(254, 0);
      ne = $urandom_range(T, 0);
      for (int e = 0; e < ne; e++) begin
        bit dup;
        do begin
          epos[e] = $urandom_range(NF - 1, 0);
          dup = 1'b0;
          for (int q = 0; q < e; q++) if (epos[q] == epos[e]) dup = 1'b1;
        end while (dup);
      end
      run_search(n, ne, s[0]);
    end

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule